// File: doc/BRIEF.md
# Flash command interface

This block is the control side of a byte-wide flash memory. It watches active-low chip enable, output enable, write enable and a combined reset/powerdown pin, plus two status inputs: a write-permit level that stands in for the programming supply, and a supply-ok level. From these it classifies each clock cycle as a read, an output-disabled cycle, standby, deep powerdown, lockout or a command write. Written command bytes select what reads return: the storage array, the two identifier bytes, or a status byte.

Changing the contents takes a two-cycle sequence. A setup byte is followed by the data byte for a byte program, or by a confirm byte for a block erase. The change starts only when the write-permit input is high. A counter holds the ready output low for a fixed number of cycles in place of the real program or erase algorithm, and the small behavioural array is updated when that count finishes. All interface logic is clocked by `clk`. Each cycle that meets the write condition counts as one command write.

Top module: `flash_cmd_if`

## Requirements
- R1: After `rst` the read mode is array, every array byte reads 0xFF, and `ready` is 1.
- R2: `dq_oe` is 1 only when `pwd_n`=1, `supply_ok`=1, `ce_n`=0, `oe_n`=0 and `we_n`=1, all in the same cycle. In every other cycle `dq_oe` is 0 and `dout` is 0x00, and this includes the cycle where `oe_n` and `we_n` are both low.
- R3: With `ce_n`=1 nothing is driven, whatever `oe_n` is. An operation already started keeps counting and commits normally.
- R4: While `pwd_n`=0 nothing is driven and `ready` is 1 in that same cycle. At each clock edge in powerdown, a running operation is abandoned without changing the array, the error bits and any half-entered sequence are cleared, and the read mode returns to array. The array contents are kept.
- R5: In identifier mode (command 0x90), `addr[0]`=0 reads 0x89 and `addr[0]`=1 reads 0xA2.
- R6: In status mode (command 0x70) the byte is {ready, 0, erase error, write error, permit error, 3'b000}, from bit 7 down to bit 0. Command 0x50 clears bits 5, 4 and 3.
- R7: Command 0xFF selects array read. A first-cycle byte that is not one of 0xFF, 0x90, 0x70, 0x50, 0x40 or 0x20 is ignored and leaves the read mode unchanged.
- R8: 0x40 followed by a data byte with `write_permit`=1 drives `ready` low for exactly BUSY_CYCLES cycles. The byte is stored at the address of the second cycle when the count ends. Both setup bytes switch reads to status mode.
- R9: 0x20 followed by 0xD0 with `write_permit`=1 is busy for BUSY_CYCLES cycles. It then sets to 0xFF every byte whose address matches the confirm address in all bits above the low BLK_W bits. Other blocks are untouched.
- R10: If the second cycle of an erase sequence is not 0xD0, the sequence ends. Status bits 5 and 4 are set, no operation starts, and the array is unchanged.
- R11: If `write_permit`=0 on the second cycle of a valid sequence, no operation starts and the array is unchanged. Bit 3 is set, together with bit 4 for a program or bit 5 for an erase.
- R12: Command writes that arrive while `ready` is low are ignored, including read-mode changes.
- R13: While `supply_ok`=0 no read is driven and no command write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| pwd_n | input | 1 | Reset/deep powerdown, active low |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address; bit 0 picks the identifier byte |
| din | input | 8 | Data or command byte written in |
| write_permit | input | 1 | High when program/erase is allowed |
| supply_ok | input | 1 | Low means lockout |
| dout | output | 8 | Read data, 0x00 when not driven |
| dq_oe | output | 1 | High when `dout` is driven onto the bus |
| ready | output | 1 | High when no program/erase is running |

## Verification
The read outputs `dout` and `dq_oe` follow the pins and the stored state within the same cycle. State changes from a command write therefore appear in the cycle after the capturing edge. `ready` falls in the cycle right after the second command cycle and rises BUSY_CYCLES cycles later, and the array change becomes readable in that same cycle. `ready` also rises as soon as `pwd_n` goes low, in that same cycle. The reference model advances on each rising edge from the pin values that were stable at that edge. Inputs change 1 ns after the edge, and every output is compared half a period later, so each result is checked in the exact cycle in which it is due.

// File: rtl/flash_ci_pkg.sv
package flash_ci_pkg;

    localparam int DATA_W = 8;
    typedef logic [DATA_W-1:0] byte_t;

    localparam byte_t CMD_RD_ARRAY = 8'hFF;
    localparam byte_t CMD_RD_ID    = 8'h90;
    localparam byte_t CMD_RD_STAT  = 8'h70;
    localparam byte_t CMD_CLR_STAT = 8'h50;
    localparam byte_t CMD_PROG     = 8'h40;
    localparam byte_t CMD_ERASE    = 8'h20;
    localparam byte_t CMD_CONFIRM  = 8'hD0;

    localparam byte_t ID_MAKER  = 8'h89;
    localparam byte_t ID_DEVICE = 8'hA2;
    localparam byte_t ERASED    = 8'hFF;

    typedef enum logic [1:0] {RM_ARRAY, RM_IDENT, RM_STATUS} rd_mode_e;

    typedef enum logic [2:0] {
        BUS_PWRDN, BUS_LOCKED, BUS_STANDBY, BUS_OUTDIS, BUS_READ, BUS_WRITE
    } bus_op_e;

    typedef enum logic [1:0] {SEQ_IDLE, SEQ_PROG, SEQ_ERASE} seq_e;

    typedef enum logic [1:0] {OP_NONE, OP_PROG, OP_ERASE} op_e;

    typedef struct packed {
        logic erase_err;
        logic write_err;
        logic permit_err;
    } stat_err_t;

    function automatic byte_t status_byte(input logic rdy, input stat_err_t e);
        return {rdy, 1'b0, e.erase_err, e.write_err, e.permit_err, 3'b000};
    endfunction

    function automatic byte_t ident_byte(input logic sel);
        return sel ? ID_DEVICE : ID_MAKER;
    endfunction

endpackage

// File: rtl/flash_bus_decode.sv
module flash_bus_decode
    import flash_ci_pkg::*;
(
    input  logic    pwd_n,
    input  logic    supply_ok,
    input  logic    ce_n,
    input  logic    oe_n,
    input  logic    we_n,
    output bus_op_e bus_op
);

    // Priority: powerdown, then lockout, then chip select, then direction.
    always_comb begin
        if (!pwd_n)                 bus_op = BUS_PWRDN;
        else if (!supply_ok)        bus_op = BUS_LOCKED;
        else if (ce_n)              bus_op = BUS_STANDBY;
        else if (!oe_n && we_n)     bus_op = BUS_READ;
        else if (oe_n && !we_n)     bus_op = BUS_WRITE;
        else                        bus_op = BUS_OUTDIS;
    end

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
    import flash_ci_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int BUSY_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_op_e           bus_op,
    input  logic [ADDR_W-1:0] addr,
    input  byte_t             din,
    input  logic              permit,
    output rd_mode_e          rd_mode,
    output logic              busy,
    output stat_err_t         err,
    output logic              commit_wr,
    output logic              commit_er,
    output logic [ADDR_W-1:0] op_addr,
    output byte_t             op_data
);

    localparam int CNT_W = (BUSY_CYCLES > 1) ? $clog2(BUSY_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYCLES - 1);

    rd_mode_e          mode_q;
    seq_e              seq_q;
    op_e               op_q;
    logic              busy_q;
    logic [CNT_W-1:0]  cnt_q;
    stat_err_t         err_q;
    logic [ADDR_W-1:0] addr_q;
    byte_t             data_q;

    always_ff @(posedge clk) begin
        if (rst || bus_op == BUS_PWRDN) begin
            mode_q <= RM_ARRAY;
            seq_q  <= SEQ_IDLE;
            op_q   <= OP_NONE;
            busy_q <= 1'b0;
            cnt_q  <= '0;
            err_q  <= '0;
            addr_q <= '0;
            data_q <= '0;
        end else if (busy_q) begin
            // Algorithm timer; command writes are not looked at here.
            if (cnt_q == '0) begin
                busy_q <= 1'b0;
                op_q   <= OP_NONE;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end else if (bus_op == BUS_WRITE) begin
            unique case (seq_q)
                SEQ_PROG: begin
                    seq_q  <= SEQ_IDLE;
                    mode_q <= RM_STATUS;
                    if (permit) begin
                        busy_q <= 1'b1;
                        cnt_q  <= CNT_LOAD;
                        op_q   <= OP_PROG;
                        addr_q <= addr;
                        data_q <= din;
                    end else begin
                        err_q.permit_err <= 1'b1;
                        err_q.write_err  <= 1'b1;
                    end
                end
                SEQ_ERASE: begin
                    seq_q  <= SEQ_IDLE;
                    mode_q <= RM_STATUS;
                    if (din != CMD_CONFIRM) begin
                        err_q.erase_err <= 1'b1;
                        err_q.write_err <= 1'b1;
                    end else if (permit) begin
                        busy_q <= 1'b1;
                        cnt_q  <= CNT_LOAD;
                        op_q   <= OP_ERASE;
                        addr_q <= addr;
                    end else begin
                        err_q.permit_err <= 1'b1;
                        err_q.erase_err  <= 1'b1;
                    end
                end
                default: begin
                    case (din)
                        CMD_RD_ARRAY: mode_q <= RM_ARRAY;
                        CMD_RD_ID:    mode_q <= RM_IDENT;
                        CMD_RD_STAT:  mode_q <= RM_STATUS;
                        CMD_CLR_STAT: err_q  <= '0;
                        CMD_PROG: begin
                            seq_q  <= SEQ_PROG;
                            mode_q <= RM_STATUS;
                        end
                        CMD_ERASE: begin
                            seq_q  <= SEQ_ERASE;
                            mode_q <= RM_STATUS;
                        end
                        default: ;
                    endcase
                end
            endcase
        end
    end

    logic finishing;
    assign finishing = busy_q && (cnt_q == '0) && (bus_op != BUS_PWRDN);
    assign commit_wr = finishing && (op_q == OP_PROG);
    assign commit_er = finishing && (op_q == OP_ERASE);
    assign rd_mode   = mode_q;
    assign busy      = busy_q;
    assign err       = err_q;
    assign op_addr   = addr_q;
    assign op_data   = data_q;

    a_r4_pwrdn_resets: assert property (@(posedge clk) disable iff (rst)
        (bus_op == BUS_PWRDN) |=> (mode_q == RM_ARRAY && !busy_q && err_q == '0));

    a_r12_busy_holds_mode: assert property (@(posedge clk) disable iff (rst)
        (busy_q && bus_op != BUS_PWRDN) |=> (mode_q == $past(mode_q)));

    a_r8_busy_keeps_running: assert property (@(posedge clk) disable iff (rst)
        (busy_q && cnt_q != '0 && bus_op != BUS_PWRDN) |=> busy_q);

    a_r11_no_start_without_permit: assert property (@(posedge clk) disable iff (rst)
        (!busy_q && bus_op == BUS_WRITE && seq_q != SEQ_IDLE && !permit) |=> !busy_q);

    a_r10_abort_flags: assert property (@(posedge clk) disable iff (rst)
        (!busy_q && bus_op == BUS_WRITE && seq_q == SEQ_ERASE && din != CMD_CONFIRM)
        |=> (!busy_q && err_q.erase_err && err_q.write_err));

endmodule

// File: rtl/flash_array.sv
module flash_array
    import flash_ci_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int BLK_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] rd_addr,
    output byte_t             rd_data,
    input  logic              wr_en,
    input  logic              er_en,
    input  logic [ADDR_W-1:0] op_addr,
    input  byte_t             wr_data
);

    localparam int DEPTH = 1 << ADDR_W;

    byte_t cells [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        localparam logic [ADDR_W-1:0] CELL_A = ADDR_W'(i);
        byte_t cell_q;
        logic  in_block;
        assign in_block = (op_addr >> BLK_W) == (CELL_A >> BLK_W);
        always_ff @(posedge clk) begin
            if (rst)                            cell_q <= ERASED;
            else if (er_en && in_block)         cell_q <= ERASED;
            else if (wr_en && op_addr == CELL_A) cell_q <= wr_data;
        end
        assign cells[i] = cell_q;
    end

    assign rd_data = cells[rd_addr];

    a_r9_single_commit: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && er_en));

endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
    import flash_ci_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int BLK_W       = 4,
    parameter int BUSY_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwd_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    input  logic              write_permit,
    input  logic              supply_ok,
    output logic [7:0]        dout,
    output logic              dq_oe,
    output logic              ready
);

    bus_op_e           bus_op;
    rd_mode_e          rd_mode;
    logic              busy;
    stat_err_t         err;
    logic              commit_wr;
    logic              commit_er;
    logic [ADDR_W-1:0] op_addr;
    byte_t             op_data;
    byte_t             arr_rd;

    flash_bus_decode u_decode (
        .pwd_n     (pwd_n),
        .supply_ok (supply_ok),
        .ce_n      (ce_n),
        .oe_n      (oe_n),
        .we_n      (we_n),
        .bus_op    (bus_op)
    );

    flash_cmd_fsm #(.ADDR_W(ADDR_W), .BUSY_CYCLES(BUSY_CYCLES)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .bus_op    (bus_op),
        .addr      (addr),
        .din       (din),
        .permit    (write_permit),
        .rd_mode   (rd_mode),
        .busy      (busy),
        .err       (err),
        .commit_wr (commit_wr),
        .commit_er (commit_er),
        .op_addr   (op_addr),
        .op_data   (op_data)
    );

    flash_array #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_array (
        .clk     (clk),
        .rst     (rst),
        .rd_addr (addr),
        .rd_data (arr_rd),
        .wr_en   (commit_wr),
        .er_en   (commit_er),
        .op_addr (op_addr),
        .wr_data (op_data)
    );

    always_comb begin
        dout = '0;
        if (bus_op == BUS_READ) begin
            unique case (rd_mode)
                RM_ARRAY: dout = arr_rd;
                RM_IDENT: dout = ident_byte(addr[0]);
                default:  dout = status_byte(!busy, err);
            endcase
        end
    end

    assign dq_oe = (bus_op == BUS_READ);
    assign ready = !busy || !pwd_n;

    a_r3_standby_floats: assert property (@(posedge clk) disable iff (rst)
        ce_n |-> (!dq_oe && dout == '0));

    a_r4_pwrdn_ready: assert property (@(posedge clk) disable iff (rst)
        !pwd_n |-> (ready && !dq_oe));

    a_r13_lockout_floats: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |-> !dq_oe);

endmodule

// File: tb/tb_flash_cmd_if.sv
`timescale 1ns/100ps
module tb_flash_cmd_if;

    localparam int ADDR_W      = 6;
    localparam int BLK_W       = 4;
    localparam int BUSY_CYCLES = 4;
    localparam int DEPTH       = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              pwd_n = 1'b1;
    logic              ce_n = 1'b1;
    logic              oe_n = 1'b1;
    logic              we_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0]        din = '0;
    logic              write_permit = 1'b0;
    logic              supply_ok = 1'b1;
    logic [7:0]        dout;
    logic              dq_oe;
    logic              ready;

    always #2.5 clk = ~clk;

    flash_cmd_if #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .BUSY_CYCLES(BUSY_CYCLES)) dut (
        .clk(clk), .rst(rst), .pwd_n(pwd_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .write_permit(write_permit), .supply_ok(supply_ok),
        .dout(dout), .dq_oe(dq_oe), .ready(ready)
    );

    int    checks = 0;
    int    fails  = 0;
    string cur_req = "R1";

    // Behavioural reference: mode 0 array, 1 identifier, 2 status;
    // seq 0 none, 1 program pending, 2 erase pending; op 1 program, 2 erase.
    int m_mode, m_seq, m_cnt, m_op, m_paddr, m_pdata;
    bit m_busy, m_e, m_w, m_p;
    int mem [DEPTH];

    task automatic model_step();
        bit wr_cyc;
        if (rst) begin
            m_mode = 0; m_seq = 0; m_busy = 0; m_cnt = 0; m_op = 0;
            m_e = 0; m_w = 0; m_p = 0;
            foreach (mem[k]) mem[k] = 8'hFF;
        end else if (!pwd_n) begin
            m_mode = 0; m_seq = 0; m_busy = 0; m_op = 0;
            m_e = 0; m_w = 0; m_p = 0;
        end else if (m_busy) begin
            if (m_cnt == 0) begin
                if (m_op == 1) mem[m_paddr] = m_pdata;
                if (m_op == 2)
                    foreach (mem[k])
                        if ((k >> BLK_W) == (m_paddr >> BLK_W)) mem[k] = 8'hFF;
                m_busy = 0; m_op = 0;
            end else begin
                m_cnt--;
            end
        end else begin
            wr_cyc = supply_ok && !ce_n && oe_n && !we_n;
            if (wr_cyc) begin
                if (m_seq == 1) begin
                    m_seq = 0; m_mode = 2;
                    if (write_permit) begin
                        m_busy = 1; m_cnt = BUSY_CYCLES - 1; m_op = 1;
                        m_paddr = int'(addr); m_pdata = int'(din);
                    end else begin m_p = 1; m_w = 1; end
                end else if (m_seq == 2) begin
                    m_seq = 0; m_mode = 2;
                    if (din != 8'hD0) begin m_e = 1; m_w = 1; end
                    else if (write_permit) begin
                        m_busy = 1; m_cnt = BUSY_CYCLES - 1; m_op = 2; m_paddr = int'(addr);
                    end else begin m_p = 1; m_e = 1; end
                end else begin
                    case (din)
                        8'hFF: m_mode = 0;
                        8'h90: m_mode = 1;
                        8'h70: m_mode = 2;
                        8'h50: begin m_e = 0; m_w = 0; m_p = 0; end
                        8'h40: begin m_seq = 1; m_mode = 2; end
                        8'h20: begin m_seq = 2; m_mode = 2; end
                        default: ;
                    endcase
                end
            end
        end
    endtask

    always @(posedge clk) model_step();

    function automatic logic exp_oe();
        return pwd_n && supply_ok && !ce_n && !oe_n && we_n;
    endfunction

    function automatic logic [7:0] exp_dout();
        if (!exp_oe()) return 8'h00;
        if (m_mode == 0) return 8'(mem[addr]);
        if (m_mode == 1) return addr[0] ? 8'hA2 : 8'h89;
        return {~m_busy, 1'b0, m_e, m_w, m_p, 3'b000};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison against the reference model.
    always @(negedge clk) begin
        if (!rst) begin
            check(cur_req, "dq_oe", 32'(dq_oe), 32'(exp_oe()));
            check(cur_req, "ready", 32'(ready), 32'(!m_busy || !pwd_n));
            check(cur_req, "dout",  32'(dout),  32'(exp_dout()));
        end
    end

    task automatic idle();
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b0; addr = a; din = d;
        @(posedge clk); #1;
        idle();
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input logic [7:0] exp, input string req);
        @(posedge clk); #1;
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
        @(negedge clk);
        check(req, "read value", 32'(dout), 32'(exp));
        check(req, "read drive", 32'(dq_oe), 32'd1);
        #1 idle();
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!ready) @(negedge clk);
    endtask

    function automatic void summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endfunction

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        cur_req = "R1";
        @(negedge clk);
        check("R1", "ready after reset", 32'(ready), 32'd1);
        check("R1", "no drive after reset", 32'(dq_oe), 32'd0);
        rd(6'd0, 8'hFF, "R1");
        rd(6'd63, 8'hFF, "R1");

        // R2: both strobes low drives nothing
        cur_req = "R2";
        @(posedge clk); #1;
        ce_n = 0; oe_n = 0; we_n = 0; din = 8'h11;
        @(negedge clk);
        check("R2", "oe and we low", 32'(dq_oe), 32'd0);
        check("R2", "dout idle", 32'(dout), 32'd0);
        #1 idle();

        // R5: identifier codes
        cur_req = "R5";
        wr(0, 8'h90);
        rd(6'd0, 8'h89, "R5");
        rd(6'd1, 8'hA2, "R5");

        // R7: unknown command ignored, 0xFF back to array
        cur_req = "R7";
        wr(0, 8'h11);
        rd(6'd3, 8'hA2, "R7");
        wr(0, 8'hFF);
        rd(6'd3, 8'hFF, "R7");

        // R6: status read
        cur_req = "R6";
        wr(0, 8'h70);
        rd(6'd0, 8'h80, "R6");

        // R8: byte program with permit
        cur_req = "R8";
        write_permit = 1'b1;
        wr(0, 8'h40);
        wr(6'd5, 8'h5A);
        begin
            int n = 0;
            repeat (BUSY_CYCLES + 2) begin
                @(negedge clk);
                if (!ready) n++;
            end
            check("R8", "busy length", 32'(n), 32'(BUSY_CYCLES));
        end
        rd(6'd5, 8'h80, "R8");
        wr(0, 8'hFF);
        rd(6'd5, 8'h5A, "R8");

        // R12: command during busy ignored
        cur_req = "R12";
        wr(0, 8'h40);
        wr(6'd6, 8'h11);
        wr(0, 8'h90);
        wait_idle();
        rd(6'd1, 8'h80, "R12");
        wr(0, 8'hFF);
        rd(6'd6, 8'h11, "R12");

        // R11: no permit
        cur_req = "R11";
        write_permit = 1'b0;
        wr(0, 8'h40);
        wr(6'd7, 8'h22);
        check("R11", "no busy", 32'(ready), 32'd1);
        rd(6'd0, 8'h98, "R11");
        wr(0, 8'hFF);
        rd(6'd7, 8'hFF, "R11");
        wr(0, 8'h50);
        wr(6'h10, 8'h20);
        wr(6'h10, 8'hD0);
        rd(6'd0, 8'hA8, "R11");
        wr(0, 8'h50);
        wr(0, 8'h70);
        rd(6'd0, 8'h80, "R6");

        // R10: erase abort
        cur_req = "R10";
        write_permit = 1'b1;
        wr(0, 8'h20);
        wr(0, 8'h33);
        check("R10", "no busy", 32'(ready), 32'd1);
        rd(6'd0, 8'hB0, "R10");
        wr(0, 8'h50);
        wr(0, 8'hFF);
        rd(6'd5, 8'h5A, "R10");

        // R9: block erase
        cur_req = "R9";
        wr(0, 8'h40);
        wr(6'h12, 8'h3C);
        wait_idle();
        wr(6'd3, 8'h20);
        wr(6'd3, 8'hD0);
        wait_idle();
        wr(0, 8'hFF);
        rd(6'd5, 8'hFF, "R9");
        rd(6'd6, 8'hFF, "R9");
        rd(6'h12, 8'h3C, "R9");

        // R3: deselect during an operation
        cur_req = "R3";
        wr(0, 8'h40);
        wr(6'd8, 8'h77);
        @(posedge clk); #1;
        ce_n = 1; oe_n = 0; we_n = 1;
        @(negedge clk);
        check("R3", "standby no drive", 32'(dq_oe), 32'd0);
        check("R3", "still busy", 32'(ready), 32'd0);
        wait_idle();
        idle();
        wr(0, 8'hFF);
        rd(6'd8, 8'h77, "R3");

        // R4: powerdown aborts and restores array mode
        cur_req = "R4";
        wr(0, 8'h40);
        wr(6'd9, 8'h44);
        @(posedge clk); #1;
        pwd_n = 0; ce_n = 0; oe_n = 0; we_n = 1;
        @(negedge clk);
        check("R4", "ready in powerdown", 32'(ready), 32'd1);
        check("R4", "no drive in powerdown", 32'(dq_oe), 32'd0);
        repeat (3) @(posedge clk);
        #1 pwd_n = 1; idle();
        rd(6'd9, 8'hFF, "R4");
        rd(6'h12, 8'h3C, "R4");

        // R13: lockout
        cur_req = "R13";
        supply_ok = 1'b0;
        wr(0, 8'h90);
        @(posedge clk); #1;
        ce_n = 0; oe_n = 0; we_n = 1;
        @(negedge clk);
        check("R13", "no drive in lockout", 32'(dq_oe), 32'd0);
        #1 idle();
        supply_ok = 1'b1;
        rd(6'd0, 8'hFF, "R13");

        repeat (2) @(posedge clk);
        summary();
        $finish;
    end

endmodule